// File: doc/BRIEF.md
# Register Write-Protection Controller

This block holds the configuration registers of a memory controller behind a simple register bus. The bus has separate write and read addresses, so a write and a read can be issued in the same cycle. Eight configuration words sit at word offsets 0 to 7:

- operating mode
- refresh interval
- geometry configuration
- three timing words
- device type
- fast-path settings

Their contents are brought out on a flat vector that the controller core consumes.

A guard register at offset 8 holds a single enable bit. While that bit is set, any write aimed at one of the eight configuration words is dropped. The block then raises a sticky violation flag and records the word offset of the refused target. Both are visible in a read-only status word at offset 9. Reading that word clears the flag, but a violation that arrives in the same cycle as the read wins, so no event is lost. The guard register is never guarded, so software can always lower the protection again.

Top module: `cfg_wp_regfile`

## Requirements
- R1: After reset, all eight configuration words, the guard enable and the violation flag read as zero, and `cfg_q` is all zero.
- R2: With the guard enable (bit 0 of offset 8) clear, a write to offset k (0 to 7) stores the data. A read of offset k, and slice k of `cfg_q` (bits k*DATA_W upward), return that data from the cycle after the write.
- R3: With the guard enable set, a write to offset 0 to 7 leaves every configuration word unchanged.
- R4: A write refused under R3 sets the violation flag, bit 0 of the status word at offset 9, from the next cycle.
- R5: Each refused write loads its target offset, zero-extended, into the source field, bits 15:8 of the status word. The field therefore shows the most recent violation and keeps that value when the flag is cleared.
- R6: A read of offset 9 returns the flag value held before the read, and the flag reads zero from the next cycle.
- R7: If a refused write and a status read occur in the same cycle, the flag is set in the following cycle.
- R8: The guard register at offset 8 is writable whatever its current value. Reads of offset 8 return the enable in bit 0, with all other bits zero.
- R9: A write to offset 9 or to an unmapped offset changes no register and does not raise the flag. Reads of unmapped offsets, and all cycles without a read, return zero.
- R10: A write to offset 0 to 7 with the guard enable clear does not raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Word offset of the read |
| rd_data | output | DATA_W | Combinational read data, zero when idle |
| cfg_q | output | NPROT*DATA_W | Configuration words, word k in slice k |

## Verification
The bench instantiates the block with DATA_W set to 16 and ADDR_W set to 6. The narrow data width keeps every expected status word a short literal, with the flag and source field in fixed bit positions. The 6-bit address leaves offsets 10 to 63 unmapped, so writes and reads outside the map (R9) can be exercised. The separate read and write addresses make the same-cycle collision of a refused write and a status read (R7) reachable directly from the bench.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_SRC_LSB  = 8;
  localparam int STAT_SRC_W    = 8;
  localparam int STAT_W        = STAT_SRC_LSB + STAT_SRC_W;

  // Status word: flag in bit 0, source offset in the upper byte.
  function automatic logic [STAT_W-1:0] pack_status(input logic flag,
                                                    input logic [STAT_SRC_W-1:0] src);
    logic [STAT_W-1:0] w;
    w = '0;
    w[STAT_FLAG_BIT] = flag;
    w[STAT_SRC_LSB +: STAT_SRC_W] = src;
    return w;
  endfunction

  // Next value of the sticky flag; a new violation wins over a clearing read.
  function automatic logic next_flag(input logic cur, input logic viol, input logic clr);
    return viol | (cur & ~clr);
  endfunction
endpackage

// File: rtl/wp_decode.sv
module wp_decode #(
  parameter int ADDR_W    = 8,
  parameter int NPROT     = 8,
  parameter int GUARD_OFS = 8,
  parameter int STAT_OFS  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NPROT-1:0]  prot_sel,
  output logic              guard_hit,
  output logic              stat_hit
);
  for (genvar k = 0; k < NPROT; k++) begin : g_sel
    assign prot_sel[k] = (addr == ADDR_W'(k));
  end
  assign guard_hit = (addr == ADDR_W'(GUARD_OFS));
  assign stat_hit  = (addr == ADDR_W'(STAT_OFS));
endmodule

// File: rtl/wp_cfg_bank.sv
module wp_cfg_bank #(
  parameter int DATA_W = 32,
  parameter int NPROT  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPROT-1:0]        we,
  input  logic [DATA_W-1:0]       wdata,
  output logic [NPROT*DATA_W-1:0] q
);
  for (genvar k = 0; k < NPROT; k++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (we[k]) word_q <= wdata;
    end
    assign q[k*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W = 8,
  parameter int SRC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              en_d,
  input  logic              viol,
  input  logic [ADDR_W-1:0] viol_ofs,
  input  logic              stat_rd,
  output logic              en_q,
  output logic              flag_q,
  output logic [SRC_W-1:0]  src_q
);
  import wp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= next_flag(flag_q, viol, stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    src_q <= '0;
    else if (viol) src_q <= SRC_W'(viol_ofs);
  end
endmodule

// File: rtl/cfg_wp_regfile.sv
module cfg_wp_regfile #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NPROT     = 8,
  parameter int GUARD_OFS = 8,
  parameter int STAT_OFS  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [NPROT*DATA_W-1:0] cfg_q
);
  import wp_pkg::*;
  localparam int SRC_W = STAT_SRC_W;

  logic [NPROT-1:0] wsel, rsel;
  logic             w_guard, w_stat, r_guard, r_stat;

  // Named internal events, observed by the checker
  logic             prot_hit;
  logic             viol_evt;
  logic             stat_rd;
  logic             guard_we;
  logic [NPROT-1:0] bank_we;
  logic             guard_en, flag;
  logic [SRC_W-1:0] src;

  wp_decode #(.ADDR_W(ADDR_W), .NPROT(NPROT), .GUARD_OFS(GUARD_OFS), .STAT_OFS(STAT_OFS))
    u_wdec (.addr(wr_addr), .prot_sel(wsel), .guard_hit(w_guard), .stat_hit(w_stat));

  wp_decode #(.ADDR_W(ADDR_W), .NPROT(NPROT), .GUARD_OFS(GUARD_OFS), .STAT_OFS(STAT_OFS))
    u_rdec (.addr(rd_addr), .prot_sel(rsel), .guard_hit(r_guard), .stat_hit(r_stat));

  assign prot_hit = wr_en & (|wsel);
  assign viol_evt = prot_hit & guard_en;
  assign bank_we  = wsel & {NPROT{wr_en & ~guard_en}};
  assign guard_we = wr_en & w_guard;
  assign stat_rd  = rd_en & r_stat;

  wp_cfg_bank #(.DATA_W(DATA_W), .NPROT(NPROT))
    u_bank (.clk(clk), .rst_n(rst_n), .we(bank_we), .wdata(wr_data), .q(cfg_q));

  wp_guard #(.ADDR_W(ADDR_W), .SRC_W(SRC_W))
    u_guard (.clk(clk), .rst_n(rst_n), .en_we(guard_we), .en_d(wr_data[0]),
             .viol(viol_evt), .viol_ofs(wr_addr), .stat_rd(stat_rd),
             .en_q(guard_en), .flag_q(flag), .src_q(src));

  // Status writes (w_stat) are deliberately ignored: the word is read-only.
  logic unused_w_stat;
  assign unused_w_stat = w_stat;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      for (int k = 0; k < NPROT; k++)
        if (rsel[k]) rd_data = cfg_q[k*DATA_W +: DATA_W];
      if (r_guard) rd_data = DATA_W'(guard_en);
      if (r_stat)  rd_data = DATA_W'(pack_status(flag, src));
    end
  end
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NPROT  = 8,
  parameter int SRC_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [DATA_W-1:0]       wr_data,
  input logic                    viol_evt,
  input logic                    stat_rd,
  input logic                    guard_we,
  input logic                    guard_en,
  input logic                    flag,
  input logic [SRC_W-1:0]        src,
  input logic [NPROT*DATA_W-1:0] cfg_q
);
  AST_BLOCKED_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> $stable(cfg_q)); // R3

  AST_VIOL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> flag); // R4

  AST_SRC_TRACKS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> src == SRC_W'($past(wr_addr))); // R5

  AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !viol_evt) |=> !flag); // R6

  AST_COLLISION_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && viol_evt) |=> flag); // R7

  AST_GUARD_ALWAYS_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    guard_we |=> guard_en == $past(wr_data[0])); // R8

  AST_FLAG_ONLY_FROM_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_evt |=> !$rose(flag)); // R10
endmodule

bind cfg_wp_regfile wp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NPROT(NPROT), .SRC_W(SRC_W))
  u_wp_checker (.clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
                .viol_evt(viol_evt), .stat_rd(stat_rd), .guard_we(guard_we),
                .guard_en(guard_en), .flag(flag), .src(src), .cfg_q(cfg_q));

// File: tb/test_cfg_wp_regfile.sv
module test_cfg_wp_regfile;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NP*DW-1:0] cfg_q;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk; // 200 MHz

  cfg_wp_regfile #(.DATA_W(DW), .ADDR_W(AW)) i_cfg_wp_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cfg_q(cfg_q));

  // Vector: {req, op (0 write, 1 read-check), offset, data, expected}
  localparam int NV = 22;
  localparam logic [47:0] VEC [NV] = '{
    {4'd2,  4'd0, 8'd0,  16'h1111, 16'h0000},
    {4'd2,  4'd1, 8'd0,  16'h0000, 16'h1111},  // R2
    {4'd2,  4'd0, 8'd7,  16'h7777, 16'h0000},
    {4'd2,  4'd1, 8'd7,  16'h0000, 16'h7777},  // R2
    {4'd10, 4'd1, 8'd9,  16'h0000, 16'h0000},  // R10: unguarded writes left flag low
    {4'd8,  4'd0, 8'd8,  16'hFFFF, 16'h0000},
    {4'd8,  4'd1, 8'd8,  16'h0000, 16'h0001},  // R8: only bit 0 kept
    {4'd3,  4'd0, 8'd3,  16'hBEEF, 16'h0000},
    {4'd3,  4'd1, 8'd3,  16'h0000, 16'h0000},  // R3
    {4'd4,  4'd1, 8'd9,  16'h0000, 16'h0301},  // R4 + R5
    {4'd6,  4'd1, 8'd9,  16'h0000, 16'h0300},  // R6: cleared, source kept
    {4'd3,  4'd0, 8'd0,  16'h2222, 16'h0000},
    {4'd5,  4'd0, 8'd5,  16'h5555, 16'h0000},
    {4'd5,  4'd1, 8'd9,  16'h0000, 16'h0501},  // R5: most recent
    {4'd3,  4'd1, 8'd0,  16'h0000, 16'h1111},  // R3
    {4'd9,  4'd0, 8'd9,  16'hFFFF, 16'h0000},
    {4'd9,  4'd1, 8'd9,  16'h0000, 16'h0500},  // R9: status read-only
    {4'd9,  4'd0, 8'd12, 16'hABCD, 16'h0000},
    {4'd9,  4'd1, 8'd12, 16'h0000, 16'h0000},  // R9: unmapped
    {4'd8,  4'd0, 8'd8,  16'h0000, 16'h0000},
    {4'd10, 4'd0, 8'd3,  16'h3333, 16'h0000},
    {4'd10, 4'd1, 8'd9,  16'h0000, 16'h0500}   // R10
  };

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Inputs change 1 time unit after a rising edge; combinational reads are sampled before the next edge.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    rd_en = 1'b1; rd_addr = a;
    #1 check(req, rd_data, exp);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state across the whole map
    for (int a = 0; a < 10; a++) do_read("R1", AW'(a), '0);
    check("R1", DW'(cfg_q == '0), DW'(1));

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][47:44]);
      if (VEC[i][43:40] == 4'd0) do_write(VEC[i][37:32], VEC[i][31:16]);
      else                       do_read(tag, VEC[i][37:32], VEC[i][15:0]);
    end

    // R10 / R2: write with the guard clear landed
    do_read("R10", 6'd3, 16'h3333);
    check("R2", cfg_q[7*DW +: DW], 16'h7777);

    // R7: refused write and status read in the same cycle
    do_write(6'd8, 16'h0001);
    wr_en = 1'b1; wr_addr = 6'd6; wr_data = 16'h6666;
    rd_en = 1'b1; rd_addr = 6'd9;
    #1 check("R7", rd_data, 16'h0500);  // R6: value before the read
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    do_read("R7", 6'd9, 16'h0601);
    do_read("R6", 6'd9, 16'h0600);
    do_read("R3", 6'd6, 16'h0000);
    check("R9", rd_data, 16'h0000);     // idle bus reads zero

    // R1: reset in mid-run clears everything again
    rst_n = 1'b0; #3; rst_n = 1'b1;
    @(posedge clk); #1;
    do_read("R1", 6'd8, 16'h0000);
    do_read("R1", 6'd0, 16'h0000);
    check("R1", DW'(cfg_q == '0), DW'(1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule